// File: doc/BRIEF.md
# Byte-Tracking Video Memory Write FIFO

This block buffers CPU data-port writes on their way to video memory. An accepted write goes straight into a free slot. There is no holding register in front of the queue. Each slot records four things: the 16-bit data, the target byte address, the destination code and two byte-valid flags. The flags are taken from the CPU's upper and lower strobes. On an 8-bit CPU bus they come from bit 0 of the current address instead. A byte write therefore uses a whole slot, just as a word write does. After each accepted write the running address steps by a programmable amount. Byte-per-slot streaming needs a step of 1.

The drain side issues one write request per memory cycle. With 16-bit video memory, one entry becomes one request, and its valid flags appear as the two byte write enables. With 8-bit video memory, the head index carries one extra low-order bit that tracks a half-finished entry. A two-byte entry then leaves as two single-byte writes: the even address first, then the odd address. The slot is freed only after its last valid byte has been written. When all slots are taken, the full flag stalls the CPU. A stalled write is held, not dropped.

Top module: `vram_wfifo`

## Requirements
- R1: After reset, `fifo_empty`=1, `fifo_full`=0, `mem_req`=0 and `cpu_wait`=0.
- R2: Each accepted write occupies exactly one slot. `fifo_full` rises when DEPTH (default 4) slots are occupied. While full, `cpu_wait` is high and a held `cpu_wr` is not taken. That write is taken later, intact, once a slot frees.
- R3: `addr_load` sets the running address and destination. Each accepted write advances the address by `addr_incr`, modulo 2^16. When a load and a write fall in the same cycle, the write uses the address from before the load, and the loaded value wins over the increment.
- R4: On the 16-bit CPU bus (`cpu_bus8`=0), `cpu_ustrb` marks `cpu_data[15:8]` valid and `cpu_lstrb` marks `cpu_data[7:0]` valid. A write with neither strobe is ignored: it takes no slot and does not advance the address.
- R5: On the 8-bit CPU bus (`cpu_bus8`=1), the byte is `cpu_data[7:0]`. It goes to the upper lane when address bit 0 is 0, and to the lower lane when address bit 0 is 1. The strobes are not used.
- R6: With 16-bit memory (`mem_8bit`=0), each entry gives one request. `mem_addr` is the entry address with bit 0 cleared. `mem_we_hi` and `mem_we_lo` equal the upper and lower valid flags. The enabled lanes of `mem_data` carry the data. The entry leaves when `mem_ready` is high.
- R7: With 8-bit memory (`mem_8bit`=1), each request carries one byte on `mem_data[7:0]`, with `mem_we_lo`=1 and `mem_we_hi`=0. The upper lane goes to the even address and the lower lane to the odd address, and the even byte comes first. The entry is popped only after its last valid byte.
- R8: Entries drain in write order. While `mem_req`=1 and `mem_ready`=0, the request, address and data are held.
- R9: The destination code is latched by `addr_load` (0 video RAM, 1 colour RAM, 2 scroll RAM) and kept per slot. It appears on `mem_target`. Byte writes behave the same for every destination.
- R10: A push and a pop in the same cycle leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_8bit | input | 1 | Video memory is 8 bits wide |
| cpu_bus8 | input | 1 | CPU side is an 8-bit bus |
| cpu_wr | input | 1 | Data-port write request |
| cpu_ustrb | input | 1 | Upper byte strobe (16-bit bus) |
| cpu_lstrb | input | 1 | Lower byte strobe (16-bit bus) |
| cpu_data | input | 16 | Write data |
| addr_load | input | 1 | Load the running address and destination |
| addr_value | input | 16 | Address to load |
| target_value | input | 2 | Destination code to load |
| addr_incr | input | 8 | Step added after each accepted write |
| cpu_wait | output | 1 | CPU write stalled (queue full) |
| fifo_full | output | 1 | All slots occupied |
| fifo_empty | output | 1 | No slots occupied |
| mem_req | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_addr | output | 16 | Byte address of the write |
| mem_data | output | 16 | Write data |
| mem_we_hi | output | 1 | Upper byte write enable |
| mem_we_lo | output | 1 | Lower (or only) byte write enable |
| mem_target | output | 2 | Destination code of the head entry |

## Verification
Two pairs of actions can land in the same cycle.

The first pair is a push and a pop. The bench stalls the drain to build up three entries. It then raises a write and `mem_ready` on the same edge and checks that the queue is still below full. One further write must then set `fifo_full`.

The second pair is an address load and a write. The bench asserts both on one edge. The memory stream must show the old address for that write and the loaded address for the next one.

Throughout the run, every memory request is compared with a byte-level model that the bench builds. It is compared under both memory widths and both CPU bus widths, and under intermittent `mem_ready`.

// File: rtl/vwf_pkg.sv
package vwf_pkg;

  localparam int VWF_AW = 16;
  localparam int VWF_IW = 8;

  typedef enum logic [1:0] {
    TGT_VRAM  = 2'd0,
    TGT_CRAM  = 2'd1,
    TGT_VSRAM = 2'd2,
    TGT_RSVD  = 2'd3
  } tgt_e;

  typedef struct packed {
    logic [VWF_AW-1:0] addr;
    logic [15:0]       data;
    logic              up_v;
    logic              lo_v;
    tgt_e              tgt;
  } slot_t;

  // running address after one accepted write
  function automatic logic [VWF_AW-1:0] advance_addr(input logic [VWF_AW-1:0] a,
                                                     input logic [VWF_IW-1:0] inc);
    return a + {{(VWF_AW-VWF_IW){1'b0}}, inc};
  endfunction

  // byte address for a lane of the word holding address a
  function automatic logic [VWF_AW-1:0] lane_addr(input logic [VWF_AW-1:0] a,
                                                  input logic upper);
    return {a[VWF_AW-1:1], ~upper};
  endfunction

  // form a slot from one CPU write
  function automatic slot_t build_slot(input logic bus8, input logic us, input logic ls,
                                       input logic [15:0] d, input logic [VWF_AW-1:0] a,
                                       input tgt_e t);
    slot_t s;
    s.addr = a;
    s.tgt  = t;
    if (bus8) begin
      s.data = {d[7:0], d[7:0]};
      s.up_v = ~a[0];
      s.lo_v = a[0];
    end else begin
      s.data = d;
      s.up_v = us;
      s.lo_v = ls;
    end
    return s;
  endfunction

endpackage

// File: rtl/vwf_addr_gen.sv
module vwf_addr_gen
  import vwf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [VWF_AW-1:0] load_addr,
  input  tgt_e              load_tgt,
  input  logic              accept,
  input  logic [VWF_IW-1:0] incr,
  output logic [VWF_AW-1:0] cur_addr,
  output tgt_e              cur_tgt
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      cur_tgt  <= TGT_VRAM;
    end else if (load) begin
      cur_addr <= load_addr;
      cur_tgt  <= load_tgt;
    end else if (accept) begin
      cur_addr <= advance_addr(cur_addr, incr);
    end
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !load) |=> $stable(cur_addr) && $stable(cur_tgt)); // R3

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cur_addr == $past(load_addr)); // R3

endmodule

// File: rtl/vwf_slots.sv
module vwf_slots
  import vwf_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  slot_t push_slot,
  input  logic  pop,
  input  logic  step_half,
  output slot_t head,
  output logic  head_half,
  output logic  full,
  output logic  empty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  slot_t            slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_slot;
  logic             rd_half;   // extra low-order bit of the head index
  logic [CNT_W-1:0] count_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (push && (wr_ptr == PTR_W'(g))) begin
        slot_q[g] <= push_slot;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_slot <= '0;
      rd_half <= 1'b0;
      count_q <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop) begin
        rd_slot <= bump(rd_slot);
        rd_half <= 1'b0;
      end else if (step_half) begin
        rd_half <= 1'b1;
      end
      case ({push, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign head      = slot_q[rd_slot];
  assign head_half = rd_half;
  assign full      = (count_q == CNT_W'(DEPTH));
  assign empty     = (count_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R2

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R6

  AST_PUSH_POP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> count_q == $past(count_q)); // R10

  AST_HALF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !rd_half); // R7

  AST_HALF_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    step_half |-> !rd_half); // R7

endmodule

// File: rtl/vwf_drain.sv
module vwf_drain
  import vwf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_8bit,
  input  slot_t             head,
  input  logic              head_half,
  input  logic              empty,
  input  logic              mem_ready,
  output logic              mem_req,
  output logic [VWF_AW-1:0] mem_addr,
  output logic [15:0]       mem_data,
  output logic              mem_we_hi,
  output logic              mem_we_lo,
  output logic [1:0]        mem_target,
  output logic              pop,
  output logic              step_half
);

  logic upper_turn;   // 8-bit memory: upper lane still owed
  logic last_byte;    // this request finishes the entry
  logic fire;

  always_comb begin
    mem_req    = !empty;
    upper_turn = head.up_v && !head_half;
    mem_target = head.tgt;
    if (!mem_8bit) begin
      mem_addr  = lane_addr(head.addr, 1'b1);
      mem_data  = head.data;
      mem_we_hi = head.up_v;
      mem_we_lo = head.lo_v;
      last_byte = 1'b1;
    end else begin
      mem_addr  = lane_addr(head.addr, upper_turn);
      mem_data  = {8'h00, upper_turn ? head.data[15:8] : head.data[7:0]};
      mem_we_hi = 1'b0;
      mem_we_lo = 1'b1;
      last_byte = !(upper_turn && head.lo_v);
    end
    if (empty) begin
      mem_we_hi = 1'b0;
      mem_we_lo = 1'b0;
    end
    fire      = mem_req && mem_ready;
    pop       = fire && last_byte;
    step_half = fire && !last_byte;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> mem_req && $stable(mem_addr) && $stable(mem_data)); // R8

  AST_NARROW_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_8bit && mem_req) |-> (!mem_we_hi && mem_we_lo)); // R7

  AST_SOME_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (head.up_v || head.lo_v)); // R4

  AST_EVEN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_8bit && step_half) |-> !mem_addr[0]); // R7

endmodule

// File: rtl/vram_wfifo.sv
module vram_wfifo
  import vwf_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mem_8bit,
  input  logic        cpu_bus8,
  input  logic        cpu_wr,
  input  logic        cpu_ustrb,
  input  logic        cpu_lstrb,
  input  logic [15:0] cpu_data,
  input  logic        addr_load,
  input  logic [15:0] addr_value,
  input  logic [1:0]  target_value,
  input  logic [7:0]  addr_incr,
  output logic        cpu_wait,
  output logic        fifo_full,
  output logic        fifo_empty,
  output logic        mem_req,
  input  logic        mem_ready,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_data,
  output logic        mem_we_hi,
  output logic        mem_we_lo,
  output logic [1:0]  mem_target
);

  logic              has_lane;
  logic              accept;
  logic [VWF_AW-1:0] cur_addr;
  tgt_e              cur_tgt;
  slot_t             new_slot;
  slot_t             head;
  logic              head_half;
  logic              pop;
  logic              step_half;

  assign has_lane = cpu_bus8 || cpu_ustrb || cpu_lstrb;
  assign accept   = cpu_wr && has_lane && !fifo_full;
  assign cpu_wait = cpu_wr && fifo_full;
  assign new_slot = build_slot(cpu_bus8, cpu_ustrb, cpu_lstrb, cpu_data, cur_addr, cur_tgt);

  vwf_addr_gen u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (addr_load),
    .load_addr (addr_value),
    .load_tgt  (tgt_e'(target_value)),
    .accept    (accept),
    .incr      (addr_incr),
    .cur_addr  (cur_addr),
    .cur_tgt   (cur_tgt)
  );

  vwf_slots #(.DEPTH(DEPTH)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept),
    .push_slot (new_slot),
    .pop       (pop),
    .step_half (step_half),
    .head      (head),
    .head_half (head_half),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  vwf_drain u_drain (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_8bit   (mem_8bit),
    .head       (head),
    .head_half  (head_half),
    .empty      (fifo_empty),
    .mem_ready  (mem_ready),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_data   (mem_data),
    .mem_we_hi  (mem_we_hi),
    .mem_we_lo  (mem_we_lo),
    .mem_target (mem_target),
    .pop        (pop),
    .step_half  (step_half)
  );

  AST_WAIT_HOLDS_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wait && !pop) |=> fifo_full); // R2

  AST_EMPTY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> (!mem_req && !mem_we_hi && !mem_we_lo)); // R1

endmodule

// File: tb/vram_wfifo_bench.sv
module vram_wfifo_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_8bit = 1'b0;
  logic        cpu_bus8 = 1'b0;
  logic        cpu_wr = 1'b0;
  logic        cpu_ustrb = 1'b0;
  logic        cpu_lstrb = 1'b0;
  logic [15:0] cpu_data = '0;
  logic        addr_load = 1'b0;
  logic [15:0] addr_value = '0;
  logic [1:0]  target_value = '0;
  logic [7:0]  addr_incr = 8'd1;
  logic        cpu_wait, fifo_full, fifo_empty, mem_req;
  logic        mem_ready;
  logic [15:0] mem_addr, mem_data;
  logic        mem_we_hi, mem_we_lo;
  logic [1:0]  mem_target;

  logic        ready_en = 1'b0;
  logic        stall_mode = 1'b0;
  logic [7:0]  cyc = '0;

  always #2.5 clk = ~clk;   // 200 MHz
  always @(posedge clk) cyc <= cyc + 8'd1;
  assign mem_ready = ready_en && (!stall_mode || (cyc % 8'd3) != 8'd0);

  vram_wfifo u_vram_wfifo (
    .clk(clk), .rst_n(rst_n), .mem_8bit(mem_8bit), .cpu_bus8(cpu_bus8),
    .cpu_wr(cpu_wr), .cpu_ustrb(cpu_ustrb), .cpu_lstrb(cpu_lstrb), .cpu_data(cpu_data),
    .addr_load(addr_load), .addr_value(addr_value), .target_value(target_value),
    .addr_incr(addr_incr), .cpu_wait(cpu_wait), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .mem_req(mem_req), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_we_hi(mem_we_hi),
    .mem_we_lo(mem_we_lo), .mem_target(mem_target)
  );

  typedef struct packed {
    logic        narrow;
    logic [15:0] addr;
    logic [15:0] data;
    logic        hi;
    logic        lo;
    logic [1:0]  tgt;
  } xact_t;

  xact_t       exp_q[$];
  int          n_checks = 0;
  int          n_fail = 0;
  logic [15:0] baddr = '0;
  logic [1:0]  btgt = '0;
  bit          finished = 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // bench model: the memory writes one CPU write must produce
  task automatic model_push(input bit b8, input bit u, input bit l, input logic [15:0] d);
    logic uu, ll;
    logic [15:0] dd;
    if (!b8 && !u && !l) return;            // R4: ignored
    if (b8) begin
      uu = ~baddr[0]; ll = baddr[0]; dd = {d[7:0], d[7:0]};   // R5
    end else begin
      uu = u; ll = l; dd = d;
    end
    if (!mem_8bit) begin
      exp_q.push_back({1'b0, baddr[15:1], 1'b0, dd, uu, ll, btgt});
    end else begin
      if (uu) exp_q.push_back({1'b1, baddr[15:1], 1'b0, 8'h00, dd[15:8], 1'b0, 1'b1, btgt});
      if (ll) exp_q.push_back({1'b1, baddr[15:1], 1'b1, 8'h00, dd[7:0], 1'b0, 1'b1, btgt});
    end
    baddr = baddr + {8'h00, addr_incr};     // R3
  endtask

  // monitor: every granted request against the model (R6 R7 R8 R9)
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected request", {16'h0, mem_addr, mem_data}, 64'h0);
      end else begin
        xact_t e;
        bit ok;
        e = exp_q.pop_front();
        ok = (mem_addr == e.addr) && (mem_we_hi == e.hi) && (mem_we_lo == e.lo)
             && (mem_target == e.tgt);
        if (e.narrow) ok = ok && (mem_data[7:0] == e.data[7:0]);
        else ok = ok && (!e.hi || mem_data[15:8] == e.data[15:8])
                     && (!e.lo || mem_data[7:0] == e.data[7:0]);
        check(ok, e.narrow ? "R7 R9 byte write" : "R6 R9 word write",
              {12'h0, mem_target, mem_we_hi, mem_we_lo, mem_addr, mem_data},
              {12'h0, e.tgt, e.hi, e.lo, e.addr, e.data});
      end
    end
  end

  task automatic set_addr(input logic [15:0] a, input logic [1:0] t);
    @(posedge clk) #1;
    addr_load = 1'b1; addr_value = a; target_value = t;
    @(posedge clk) #1;
    addr_load = 1'b0;
    baddr = a; btgt = t;
  endtask

  task automatic cpu_write(input bit b8, input bit u, input bit l, input logic [15:0] d);
    @(posedge clk) #1;
    cpu_bus8 = b8; cpu_ustrb = u; cpu_lstrb = l; cpu_data = d; cpu_wr = 1'b1;
    @(negedge clk);
    while (cpu_wait) @(negedge clk);
    model_push(b8, u, l, d);
    @(posedge clk) #1;
    cpu_wr = 1'b0;
  endtask

  task automatic drain_all();
    ready_en = 1'b1;
    for (int i = 0; i < 200 && !(fifo_empty && exp_q.size() == 0); i++) @(negedge clk);
    @(negedge clk);
    check(fifo_empty && exp_q.size() == 0, "R8 drained", {63'h0, fifo_empty},
          64'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(fifo_empty && !fifo_full && !mem_req && !cpu_wait, "R1 reset outputs",
          {60'h0, fifo_empty, fifo_full, mem_req, cpu_wait}, 64'h8);
    @(posedge clk) #1; rst_n = 1'b1;

    // sweep: memory width x CPU bus width x increment x stall pattern
    for (int m = 0; m < 2; m++) begin
      for (int b = 0; b < 2; b++) begin
        for (int inc = 1; inc <= 3; inc++) begin
          mem_8bit = m[0];
          addr_incr = inc[7:0];
          stall_mode = inc[0];
          ready_en = 1'b1;
          set_addr(16'h1000 + 16'(m * 37 + b * 11 + inc), 2'((m + b + inc) % 3));
          for (int k = 0; k < 6; k++) begin
            int s;
            s = (k % 3) + 1;              // R4 strobe patterns 01,10,11
            cpu_write(b[0], s[1], s[0], 16'(16'h3C5A ^ (k * 16'h1111) ^ (inc << 12)));
          end
          drain_all();
        end
      end
    end

    // R4 no-strobe write ignored, address unchanged
    mem_8bit = 1'b0; stall_mode = 1'b0; addr_incr = 8'd2;
    set_addr(16'h2000, 2'd1);
    ready_en = 1'b0;
    cpu_write(1'b0, 1'b0, 1'b0, 16'hDEAD);
    @(negedge clk);
    check(fifo_empty, "R4 strobeless write took no slot", {63'h0, fifo_empty}, 64'h1);
    cpu_write(1'b0, 1'b1, 1'b1, 16'hBEEF);   // must land at 0x2000
    drain_all();

    // R2 full, stall and late acceptance
    mem_8bit = 1'b1; addr_incr = 8'd1;
    set_addr(16'h0040, 2'd2);
    ready_en = 1'b0;
    for (int k = 0; k < 4; k++) cpu_write(1'b0, 1'b1, 1'b1, 16'(16'hA000 + k));
    @(negedge clk);
    check(fifo_full && !fifo_empty, "R2 full after four writes",
          {62'h0, fifo_full, fifo_empty}, 64'h2);
    @(posedge clk) #1;
    cpu_bus8 = 1'b1; cpu_data = 16'h0077; cpu_wr = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(cpu_wait && fifo_full, "R2 stalled while full", {62'h0, cpu_wait, fifo_full},
            64'h3);
    end
    @(posedge clk) #1;
    ready_en = 1'b1;
    @(negedge clk);
    while (cpu_wait) @(negedge clk);
    model_push(1'b1, 1'b0, 1'b0, 16'h0077);
    @(posedge clk) #1;
    cpu_wr = 1'b0;
    drain_all();

    // R8 request held while not ready
    mem_8bit = 1'b0;
    set_addr(16'h0300, 2'd0);
    ready_en = 1'b0;
    cpu_write(1'b0, 1'b1, 1'b0, 16'h5500);
    begin
      logic [15:0] a0, d0;
      @(negedge clk);
      a0 = mem_addr; d0 = mem_data;
      repeat (3) @(negedge clk);
      check(mem_req && mem_addr == a0 && mem_data[15:8] == d0[15:8], "R8 held request",
            {31'h0, mem_req, mem_addr, mem_data}, {31'h0, 1'b1, a0, d0});
    end
    drain_all();

    // R10 push and pop in one cycle
    set_addr(16'h0500, 2'd1);
    ready_en = 1'b0;
    for (int k = 0; k < 3; k++) cpu_write(1'b0, 1'b0, 1'b1, 16'(16'h0010 + k));
    @(posedge clk) #1;
    cpu_bus8 = 1'b0; cpu_ustrb = 1'b1; cpu_lstrb = 1'b1; cpu_data = 16'h1234;
    cpu_wr = 1'b1; ready_en = 1'b1;
    @(negedge clk);
    check(!cpu_wait, "R10 write taken during pop", {63'h0, cpu_wait}, 64'h0);
    model_push(1'b0, 1'b1, 1'b1, 16'h1234);
    @(posedge clk) #1;
    cpu_wr = 1'b0; ready_en = 1'b0;
    @(negedge clk);
    check(!fifo_full && !fifo_empty, "R10 occupancy kept at three",
          {62'h0, fifo_full, fifo_empty}, 64'h0);
    cpu_write(1'b0, 1'b1, 1'b0, 16'h9900);
    @(negedge clk);
    check(fifo_full, "R10 one more write fills", {63'h0, fifo_full}, 64'h1);
    drain_all();

    // R3 load and write in the same cycle
    set_addr(16'h0700, 2'd0);
    addr_incr = 8'd1;
    @(posedge clk) #1;
    cpu_bus8 = 1'b0; cpu_ustrb = 1'b1; cpu_lstrb = 1'b1; cpu_data = 16'hC0DE; cpu_wr = 1'b1;
    addr_load = 1'b1; addr_value = 16'h0900; target_value = 2'd2;
    @(negedge clk);
    model_push(1'b0, 1'b1, 1'b1, 16'hC0DE);  // old address, old target
    baddr = 16'h0900; btgt = 2'd2;           // load wins over increment
    @(posedge clk) #1;
    cpu_wr = 1'b0; addr_load = 1'b0;
    cpu_write(1'b0, 1'b1, 1'b1, 16'hF00D);
    drain_all();

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule